// File: doc/BRIEF.md
# Key-Unlocked Configuration Port Decoder

This block is the register-access front end of a multi-function I/O device on an 8-bit I/O bus. It decodes three ports. A write-only lock port and an index port share one base address. A data port sits one address above the base. At power-up the block is locked. A host unlocks it by writing a key byte to the lock port. While unlocked, the host selects one of 64 configuration registers through the index port and reads or writes that register through the data port. Writing a second key byte locks the block again.

The base address comes from a strap input, which is captured while reset is held. Two of the configuration registers hold the low and high bytes of the base address, so software can move the ports elsewhere at run time. Read data is registered. It appears on `rdata` in the cycle after the read strobe and holds its value until the next read.

Top module: `cfg_key_decoder`

## Requirements
- R1: While `rst_n` is low, the block captures `strap` on every clock edge, so the value present in the last reset cycle counts. Leaving reset puts the block in the locked state with `rdata` at 0xFF and the index at 0. Register 0x12 is loaded with 0xF0 (strap 0) or 0x70 (strap 1). Register 0x13 is loaded with 0x03. All other writable registers are cleared. Changes on `strap` after reset have no effect.
- R2: The lock port and the index port share the base address, and the data port is at base + 1. A read of the base address never returns a byte written as a key; it returns the index.
- R3: A write of 0x55 to the base address while locked unlocks the block from the next cycle.
- R4: A write of 0xAA to the base address while unlocked locks the block from the next cycle. After that, both port addresses read 0xFF.
- R5: While locked, a read of any address returns 0xFF. Any write other than 0x55 to the base address leaves the index, the registers and the base unchanged.
- R6: While unlocked, a write to the base address of any byte other than 0x55 or 0xAA sets the index to that byte modulo 64. A read of the base address returns the index, zero-extended to 8 bits.
- R7: While unlocked, a write to base + 1 stores the byte into the register selected by the index. A read of base + 1 returns that register. A read of any address that is not a port returns 0xFF. Each read result appears on `rdata` one cycle after `rd_en`.
- R8: Register 0 (identity 0x3A) and register 1 (revision 0x01) are read-only, and writes to them are ignored.
- R9: Writes to registers 0x12 (base low byte) and 0x13 (base high byte) move the ports from the next cycle on. After the move, the old addresses no longer respond.
- R10: A write of 0x55 to the base address while already unlocked has no effect. The block stays unlocked and the index is unchanged.
- R11: Index bits above bit 5 are dropped. For example, writing 0x45 selects the same register as 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strap | input | 1 | Base select: 0 gives base 0x3F0, 1 gives base 0x370 |
| addr | input | 16 | I/O address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
On every cycle, the assertions check the lock and unlock transitions caused by the key bytes. They also check that a repeated unlock key changes neither the mode nor the index, that every read while locked returns 0xFF, and that neither the mode nor the base moves while the block is locked without a key write. The effects that only the bench can show are the ones that depend on stored contents: that the strap value selects the base, that the read-only registers and index wrap-around behave as required, that data-port writes are stored, and that relocation makes the old addresses go silent and the new ones respond.

// File: rtl/cfg_key_decoder.sv
module cfg_key_decoder #(
  parameter int          ADDR_W   = 16,
  parameter int          NREG     = 64,
  parameter logic [7:0]  KEY_ON   = 8'h55,
  parameter logic [7:0]  KEY_OFF  = 8'hAA,
  parameter int          BASE_LO  = 'h12,
  parameter int          BASE_HI  = 'h13,
  parameter logic [15:0] BASE_S0  = 16'h03F0,
  parameter logic [15:0] BASE_S1  = 16'h0370,
  parameter logic [7:0]  DEV_ID   = 8'h3A,
  parameter logic [7:0]  DEV_REV  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int RO_CNT = 2;

  logic             cfg_mode;
  logic [IDX_W-1:0] idx;
  logic [7:0]       regs [NREG];
  logic [15:0]      base;
  logic             hit_cfg, hit_data;
  logic [15:0]      strap_base;

  assign base       = {regs[BASE_HI], regs[BASE_LO]};
  assign hit_cfg    = addr == base[ADDR_W-1:0];
  assign hit_data   = addr == (base[ADDR_W-1:0] + ADDR_W'(1));
  assign strap_base = strap ? BASE_S1 : BASE_S0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      idx      <= '0;
      rdata    <= 8'hFF;
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
      regs[0]       <= DEV_ID;
      regs[1]       <= DEV_REV;
      regs[BASE_LO] <= strap_base[7:0];
      regs[BASE_HI] <= strap_base[15:8];
    end else begin
      if (wr_en && hit_cfg) begin
        if (!cfg_mode) begin
          if (wdata == KEY_ON) cfg_mode <= 1'b1;
        end else if (wdata == KEY_OFF) begin
          cfg_mode <= 1'b0;
        end else if (wdata != KEY_ON) begin
          idx <= wdata[IDX_W-1:0];
        end
      end
      if (wr_en && hit_data && cfg_mode && int'(idx) >= RO_CNT)
        regs[idx] <= wdata;
      if (rd_en) begin
        if (!cfg_mode)     rdata <= 8'hFF;
        else if (hit_cfg)  rdata <= 8'(idx);
        else if (hit_data) rdata <= regs[idx];
        else               rdata <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/cfg_key_decoder_chk.sv
module cfg_key_decoder_chk #(
  parameter int         ADDR_W  = 16,
  parameter int         IDX_W   = 6,
  parameter logic [7:0] KEY_ON  = 8'h55,
  parameter logic [7:0] KEY_OFF = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              cfg_mode,
  input logic [IDX_W-1:0]  idx,
  input logic [15:0]       base
);
  logic at_base;
  assign at_base = wr_en && (addr == base[ADDR_W-1:0]);

  a_r3_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && at_base && wdata == KEY_ON) |=> cfg_mode);

  a_r4_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && at_base && wdata == KEY_OFF) |=> !cfg_mode);

  a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && rd_en) |=> rdata == 8'hFF);

  a_r5_locked_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !(at_base && wdata == KEY_ON)) |=> !cfg_mode);

  a_r5_locked_base_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(base));

  a_r10_key_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && at_base && wdata == KEY_ON) |=> (cfg_mode && $stable(idx)));
endmodule

bind cfg_key_decoder cfg_key_decoder_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode), .idx(idx), .base(base)
);

// File: tb/cfg_key_decoder_tb.sv
module cfg_key_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  cfg_key_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap = ~s;
  endtask

  always @(posedge clk) rd_seen <= rd_en && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: actual=%02h expected=<none queued>", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R1 reset rdata", rdata, 8'hFF);
    // R5 locked: reads give FF, writes ignored
    rd(16'h03F0, 8'hFF, "R5 locked base read");
    rd(16'h03F1, 8'hFF, "R5 locked data read");
    wr(16'h03F0, 8'h07);
    wr(16'h03F1, 8'h99);
    rd(16'h03F0, 8'hFF, "R5 still locked");
    // R3 unlock
    wr(16'h03F0, 8'h55);
    rd(16'h03F0, 8'h00, "R3 R5 R2 index after unlock");
    // R8 read-only
    rd(16'h03F1, 8'h3A, "R8 id");
    wr(16'h03F1, 8'h11);
    rd(16'h03F1, 8'h3A, "R8 id write ignored");
    wr(16'h03F0, 8'h01);
    wr(16'h03F1, 8'h22);
    rd(16'h03F1, 8'h01, "R8 rev write ignored");
    // R6 R7 index and data
    wr(16'h03F0, 8'h05);
    rd(16'h03F0, 8'h05, "R6 index readback");
    rd(16'h03F1, 8'h00, "R1 cleared reg");
    wr(16'h03F1, 8'hC3);
    rd(16'h03F1, 8'hC3, "R7 data write");
    wr(16'h03F0, 8'h06);
    wr(16'h03F1, 8'h5A);
    rd(16'h03F1, 8'h5A, "R7 second reg");
    // R11 wrap
    wr(16'h03F0, 8'h45);
    rd(16'h03F0, 8'h05, "R11 wrap index");
    rd(16'h03F1, 8'hC3, "R11 wrap data");
    // R10 repeated key
    wr(16'h03F0, 8'h55);
    rd(16'h03F0, 8'h05, "R10 repeated key");
    rd(16'h1234, 8'hFF, "R7 unmatched address");
    // R1 base registers
    wr(16'h03F0, 8'h12);
    rd(16'h03F1, 8'hF0, "R1 base low strap0");
    wr(16'h03F0, 8'h13);
    rd(16'h03F1, 8'h03, "R1 base high strap0");
    // R9 relocation to 0x0300
    wr(16'h03F0, 8'h12);
    wr(16'h03F1, 8'h00);
    rd(16'h03F0, 8'hFF, "R9 old base silent");
    rd(16'h0300, 8'h12, "R9 new base index");
    rd(16'h0301, 8'h00, "R9 new data port");
    // R4 lock
    wr(16'h0300, 8'hAA);
    rd(16'h0300, 8'hFF, "R4 locked base");
    rd(16'h0301, 8'hFF, "R4 locked data");
    wr(16'h0300, 8'h55);
    rd(16'h0300, 8'h12, "R3 relock keeps index");

    // strap 1
    do_reset(1'b1);
    @(negedge clk);
    check("R1 reset rdata strap1", rdata, 8'hFF);
    wr(16'h03F0, 8'h55);
    rd(16'h0370, 8'hFF, "R1 old address key ignored");
    wr(16'h0370, 8'h55);
    rd(16'h0370, 8'h00, "R1 strap1 index");
    rd(16'h03F0, 8'hFF, "R1 strap1 other base silent");
    wr(16'h0370, 8'h12);
    rd(16'h0371, 8'h70, "R1 base low strap1");
    wr(16'h0370, 8'h13);
    rd(16'h0371, 8'h03, "R1 base high strap1");
    wr(16'h0370, 8'h05);
    rd(16'h0371, 8'h00, "R1 reset clears regs");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: actual=%0d pending expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule